// File: doc/BRIEF.md
# USB Device Global Control and Event Flag Registers

This block is the CPU-facing global register pair of a USB device core. One register carries device-level controls: a request bit that asks the core to drive resume signalling toward the host, and a bit that disconnects the device from the bus. The other register latches single-cycle event pulses from the USB core: suspend, start-of-frame, micro-start-of-frame, end-of-reset, wake-up, end-of-resume and upstream-resume.

Software reads and writes both registers over a byte-wide bus. A one-bit select picks the register, and a single-cycle write strobe writes it. Read data is combinational from the select. Event flags are set only by hardware and cleared only by software. The resume request is set only by software and cleared only by the core's done pulse. Per-flag enable inputs choose which latched flags drive a registered interrupt line.

Top module: `usbdev_glb_regs`

## Requirements
- R1: With `reg_sel`=0 the read data is the control register: bit 1 is the resume request, bit 0 is the disconnect bit, and bits 7..2 always read 0 whatever was written.
- R2: A control write with bit 1 = 1 sets the resume request, seen on `rsm_req` after the write edge. A control write with bit 1 = 0 leaves the request unchanged.
- R3: A `rsm_done` pulse clears the resume request at that edge. If `rsm_done` and a control write of 1 to bit 1 arrive in the same cycle, the clear wins.
- R4: `detach` follows control bit 0. A control write loads it with the written value, so 1 disconnects and 0 reconnects.
- R5: With `reg_sel`=1 the read data is the flag register. Bit 6 is upstream-resume, bit 5 end-of-resume, bit 4 wake-up, bit 3 end-of-reset, bit 2 start-of-frame, bit 1 micro-start-of-frame, bit 0 suspend, and bit 7 always reads 0. Each `evt` bit uses the same position. A 1 on an `evt` bit sets that flag at the same edge.
- R6: A flag write with a 0 in bit i clears flag i. A 1 in bit i leaves flag i unchanged and never sets it. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: A wake-up event (`evt` bit 4) is ignored while the resume request is 1, because that line activity is the device's own resume signalling.
- R8: `irq` is the OR over all flags of (flag AND matching `flag_en` bit), registered once. It changes one edge after the flags change.
- R9: After reset, the disconnect bit is 1, the resume request is 0, all flags are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 control, 1 flags |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt | input | 7 | Single-cycle event pulses from the USB core, flag bit positions |
| flag_en | input | 7 | Interrupt enable per flag |
| rsm_done | input | 1 | Core pulse: upstream resume signalling finished |
| rsm_req | output | 1 | Resume request toward the core |
| detach | output | 1 | Disconnect the device from the bus |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that `evt` and `rsm_done` are pulses lasting one cycle each, and that the write strobe lasts one cycle per access. They also assume that `rsm_done` arrives only while a resume request is pending. The properties still hold if a pulse repeats. The stimulus drives every event and write for exactly one clock between negative edges and leaves `evt` at zero otherwise. The done pulse is raised only after a resume request has been written, except in one deliberate collision cycle that tests the R3 priority.

// File: rtl/usbdev_glb_pkg.sv
package usbdev_glb_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 7;

    // register select encodings
    localparam logic SEL_CTRL  = 1'b0;
    localparam logic SEL_FLAGS = 1'b1;

    // flag bit positions (software decodes these)
    localparam int FLG_SUSP  = 0;
    localparam int FLG_USOF  = 1;
    localparam int FLG_SOF   = 2;
    localparam int FLG_EORST = 3;
    localparam int FLG_WAKE  = 4;
    localparam int FLG_EORSM = 5;
    localparam int FLG_UPRSM = 6;

    // control register contents, bit 1 then bit 0
    typedef struct packed {
        logic rmw;
        logic detach;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{rmw: 1'b0, detach: 1'b1};

    function automatic logic [DATA_W-1:0] ctrl_to_bus(ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[1:0] = c;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] flags_to_bus(logic [NUM_FLAGS-1:0] f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[NUM_FLAGS-1:0] = f;
        return v;
    endfunction

endpackage

// File: rtl/usbdev_ctrl_reg.sv
module usbdev_ctrl_reg
    import usbdev_glb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    input  logic       rsm_done,
    output ctrl_t      ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.detach = wdata[0];
            if (wdata[1]) ctrl_d.rmw = 1'b1;
        end
        // hardware clear has priority over a software set
        if (rsm_done) ctrl_d.rmw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RESET;
        else     ctrl_q <= ctrl_d;
    end

    // R3: done pulse always leaves the request cleared
    a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
        rsm_done |=> !ctrl_q.rmw);

    // R2: software zero never drops a pending request
    a_r2_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rmw && !rsm_done) |=> ctrl_q.rmw);

    // R4: detach takes the written value
    a_r4_detach_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_q.detach == $past(wdata[0])));

    // R4: detach holds without a write
    a_r4_detach_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q.detach));

endmodule

// File: rtl/usbdev_flag_reg.sv
module usbdev_flag_reg
    import usbdev_glb_pkg::*;
#(
    parameter int NF       = NUM_FLAGS,
    parameter int WAKE_BIT = FLG_WAKE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [NF-1:0] wdata,
    input  logic [NF-1:0] evt,
    input  logic          wake_mask,
    output logic [NF-1:0] flags_q
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic set_i;
        logic clr_i;

        if (i == WAKE_BIT) begin : g_wake
            assign set_i = evt[i] && !wake_mask;
        end else begin : g_plain
            assign set_i = evt[i];
        end
        assign clr_i = wr_en && !wdata[i];

        always_ff @(posedge clk) begin
            if (rst)        flags_q[i] <= 1'b0;
            else if (set_i) flags_q[i] <= 1'b1;
            else if (clr_i) flags_q[i] <= 1'b0;
        end

        // R6: without an event a flag can never rise
        a_r6_no_sw_set: assert property (@(posedge clk) disable iff (rst)
            (!flags_q[i] && !evt[i]) |=> !flags_q[i]);

        // R6: a zero written with no event clears the flag
        a_r6_clear: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wdata[i] && !evt[i]) |=> !flags_q[i]);

        if (i != WAKE_BIT) begin : g_set_chk
            // R5, R6: an event sets the flag even against a clear
            a_r5_evt_sets: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> flags_q[i]);
        end
    end

    // R7: own resume activity does not raise the wake-up flag
    a_r7_wake_masked: assert property (@(posedge clk) disable iff (rst)
        (wake_mask && !flags_q[WAKE_BIT]) |=> !flags_q[WAKE_BIT]);

endmodule

// File: rtl/usbdev_irq_gen.sv
module usbdev_irq_gen #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] flags,
    input  logic [NF-1:0] en,
    output logic          irq_q
);

    logic [NF-1:0] active;
    assign active = flags & en;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |active;
    end

    // R8: the line only rises from an enabled flag seen one edge earlier
    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(flags) & $past(en)) != '0);

    // R8: with all flags clear the line drops at the next edge
    a_r8_irq_drop: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |=> !irq_q);

endmodule

// File: rtl/usbdev_glb_regs.sv
module usbdev_glb_regs
    import usbdev_glb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_sel,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NF-1:0] evt,
    input  logic [NF-1:0] flag_en,
    input  logic          rsm_done,
    output logic          rsm_req,
    output logic          detach,
    output logic          irq
);

    ctrl_t         ctrl_q;
    logic [NF-1:0] flags_q;
    logic          ctrl_we;
    logic          flag_we;
    logic          unused_wbits;

    assign ctrl_we      = reg_we && (reg_sel == SEL_CTRL);
    assign flag_we      = reg_we && (reg_sel == SEL_FLAGS);
    assign unused_wbits = ^reg_wdata[DW-1:NF];

    usbdev_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_we),
        .wdata    (reg_wdata[1:0]),
        .rsm_done (rsm_done),
        .ctrl_q   (ctrl_q)
    );

    usbdev_flag_reg #(.NF(NF), .WAKE_BIT(FLG_WAKE)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (flag_we),
        .wdata     (reg_wdata[NF-1:0]),
        .evt       (evt),
        .wake_mask (ctrl_q.rmw),
        .flags_q   (flags_q)
    );

    usbdev_irq_gen #(.NF(NF)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .flags (flags_q),
        .en    (flag_en),
        .irq_q (irq)
    );

    assign rsm_req   = ctrl_q.rmw;
    assign detach    = ctrl_q.detach;
    assign reg_rdata = (reg_sel == SEL_CTRL) ? ctrl_to_bus(ctrl_q) : flags_to_bus(flags_q);

    // R1, R5: reserved read bits stay zero
    always_comb begin
        if (!rst) begin
            a_r1_reserved_zero: assert (reg_sel == SEL_FLAGS || reg_rdata[DW-1:2] == '0);
            a_r5_top_bit_zero:  assert (reg_rdata[DW-1] == 1'b0);
        end
    end

    // R9: reset state, observed at the first edge after reset
    a_r9_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (detach && !rsm_req && flags_q == '0 && !irq));

endmodule

// File: tb/usbdev_glb_regs_bench.sv
module usbdev_glb_regs_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_sel;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [6:0] evt;
    logic [6:0] flag_en;
    logic       rsm_done;
    logic       rsm_req;
    logic       detach;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    // 4 time units per period, read as 4 ns (250 MHz)
    always #2 clk = ~clk;

    usbdev_glb_regs u_usbdev_glb_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
        .flag_en(flag_en), .rsm_done(rsm_done), .rsm_req(rsm_req),
        .detach(detach), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        evt = '0; flag_en = '0; rsm_done = 1'b0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        tick();

        // R9 reset values
        rd(1'b0, v); chk("R9 ctrl", v, 8'h01);
        rd(1'b1, v); chk("R9 flags", v, 8'h00);
        chk("R9 irq", {7'b0, irq}, 8'h00);
        chk("R9 detach", {7'b0, detach}, 8'h01);

        // R1, R2: all ones written, reserved bits read 0
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk("R1 ctrl read", v, 8'h03);
        chk("R2 rsm_req set", {7'b0, rsm_req}, 8'h01);

        // R4 reconnect, R2 zero leaves request
        wr(1'b0, 8'hFC);
        chk("R4 detach cleared", {7'b0, detach}, 8'h00);
        chk("R2 zero no effect", {7'b0, rsm_req}, 8'h01);
        rd(1'b0, v); chk("R1 ctrl read 2", v, 8'h02);

        // R7 wake-up ignored while request pending
        evt = 7'h10; tick(); evt = '0;
        rd(1'b1, v); chk("R7 wake masked", v, 8'h00);

        // R3 done clears
        rsm_done = 1'b1; tick(); rsm_done = 1'b0;
        chk("R3 done clears", {7'b0, rsm_req}, 8'h00);

        // R3 collision: done wins over write of 1
        rsm_done = 1'b1; wr(1'b0, 8'h03); rsm_done = 1'b0;
        chk("R3 done wins", {7'b0, rsm_req}, 8'h00);
        chk("R4 detach set", {7'b0, detach}, 8'h01);

        // R5, R8: every event pattern
        for (int p = 0; p < 128; p++) begin
            logic [6:0] pp;
            pp = p[6:0];
            flag_en = pp ^ 7'h2A;
            wr(1'b1, 8'h00);
            evt = pp; tick(); evt = '0;
            rd(1'b1, v); chk("R5 flags set", v, {1'b0, pp});
            tick();
            chk("R8 irq", {7'b0, irq}, {7'b0, |(pp & (pp ^ 7'h2A))});
        end

        // R6: every clear mask with all flags set
        for (int w = 0; w < 128; w++) begin
            logic [6:0] ww;
            ww = w[6:0];
            evt = 7'h7F; tick(); evt = '0;
            wr(1'b1, {1'b1, ww});
            rd(1'b1, v); chk("R6 clear mask", v, {1'b0, ww});
        end

        // R6: a write of ones never sets
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); chk("R6 ones no set", v, 8'h00);

        // R6: event beats a simultaneous clear
        evt = 7'h41; wr(1'b1, 8'h00); evt = '0;
        rd(1'b1, v); chk("R6 set wins", v, 8'h41);

        // R8: irq drops one edge after flags clear
        flag_en = 7'h7F;
        tick();
        chk("R8 irq high", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h00);
        tick();
        chk("R8 irq low", {7'b0, irq}, 8'h00);

        // R7: wake-up accepted without a request
        evt = 7'h10; tick(); evt = '0;
        rd(1'b1, v); chk("R7 wake accepted", v, 8'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule